// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block passes short messages between an application processor and an I/O co-processor. It holds two independent 16-entry hardware queues. The outbound queue carries messages from the application side to the I/O side, and the inbound queue carries them back. A message is a 64-bit first word plus a 32-bit second word. Both processors reach every register through one shared register bus, so either side (or a testbench) can act as sender or receiver on either queue.

A sender first writes the first word, which is only staged. It then writes the second word, and that write commits the whole 96-bit message in one cycle. A receiver reads the first word of the head entry and then the second word; the second read pops the entry and also returns the queue's pointers and occupancy above the payload.

Four interrupt sources watch the queues: outbound empty, outbound not empty, inbound empty and inbound not empty. Each source latches its condition once it has been seen and holds it until software writes a 1 to that source's acknowledge bit. If the condition still holds at the acknowledge, the latch stays set. Each of the four interrupt outputs is the latch gated by its enable bit.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty: each control register reads bit 17 = 1 (empty) and bit 16 = 0 (full). The interrupt enable register reads 0 and all four interrupt outputs are low.
- R2: A write to a queue's word-0 send register only stages the word, and the queue stays empty. A write to its word-1 send register commits {word1 = wdata[31:0], staged word0} as one entry. wdata[63:32] of that write is ignored.
- R3: Each queue is first-in first-out and 16 entries deep. After 16 commits its control register reads bit 16 = 1, and entries come out in commit order.
- R4: A commit to a full queue is dropped and sets sticky bit 18 of that queue's control register. The bit clears only when 1 is written to bit 18 of the same control register.
- R5: A read of word-0 receive returns the head's first word and does not pop. A read of word-1 receive returns the head's second word in bits 31:0 and pops. On an empty queue both payloads read 0, and the pop changes nothing.
- R6: A word-1 receive read reports the state before the pop. Occupancy (0..16) sits in bits 56:52, occupancy modulo 16 in bits 51:48, the read pointer in bits 47:44 and the write pointer in bits 43:40. Bits 63:57 and 39:32 read 0.
- R7: The outbound queue uses control 0x50, send 0x60/0x68 and receive 0x70/0x78. The inbound queue uses control 0x80, send 0x90/0x98 and receive 0xA0/0xA8. Traffic on one queue leaves the other unchanged.
- R8: Interrupt enable (0x48, read/write) and acknowledge (0x4C, write; a read returns the four latches) share one layout: bit 0 outbound empty, bit 1 outbound not empty, bit 2 inbound empty, bit 3 inbound not empty.
- R9: A source's latch sets one cycle after its condition is seen and stays set after the condition clears. It clears only on an acknowledge write with a 1 in its bit. Writing 0 to an acknowledge bit has no effect.
- R10: Acknowledging a source whose condition is true at that cycle leaves its latch set on the next cycle.
- R11: Each interrupt output equals its latch AND its enable bit: irq_ap_tx_empty bit 0, irq_io_rx_ready bit 1, irq_io_tx_empty bit 2, irq_ap_rx_ready bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for the current access (same cycle) |
| irq_ap_tx_empty | output | 1 | Outbound-empty interrupt (application side) |
| irq_io_rx_ready | output | 1 | Outbound-not-empty interrupt (I/O side) |
| irq_io_tx_empty | output | 1 | Inbound-empty interrupt (I/O side) |
| irq_ap_rx_ready | output | 1 | Inbound-not-empty interrupt (application side) |

## Verification
The assertions check on every cycle that a latched source stays set until a 1 is acknowledged and that an acknowledge against a live condition keeps the latch set. They also check that a commit into a full queue neither changes the occupancy and sets the overflow flag, that a staging write or an empty pop moves nothing, and that occupancy never exceeds the depth. Only the bench scenarios can show the message contents and their order, the pointer and count fields in the receive word, the independence of the two address ranges, and the gating of each interrupt output by its enable.

// File: rtl/mbx_pkg.sv
// Package: shared widths, register offsets and field positions for the mailbox.
// Assumes an 8-bit byte-offset address and a 64-bit data bus.
package mbx_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 64;
    localparam int W0_W    = 64;
    localparam int W1_W    = 32;
    localparam int NUM_CH  = 2;
    localparam int NUM_IRQ = 4;

    typedef struct packed {
        logic [W1_W-1:0] w1;
        logic [W0_W-1:0] w0;
    } msg_t;

    localparam logic [ADDR_W-1:0] IRQ_EN_ADDR  = 8'h48;
    localparam logic [ADDR_W-1:0] IRQ_ACK_ADDR = 8'h4C;

    localparam int CTRL_FULL_BIT  = 16;
    localparam int CTRL_EMPTY_BIT = 17;
    localparam int CTRL_OVF_BIT   = 18;

    localparam int ST_OUTCNT_LSB = 52;
    localparam int ST_OUTCNT_W   = 5;
    localparam int ST_INCNT_LSB  = 48;
    localparam int ST_INCNT_W    = 4;
    localparam int ST_OUTPTR_LSB = 44;
    localparam int ST_INPTR_LSB  = 40;
    localparam int ST_PTR_W      = 4;

    // Control register offset of a channel (0 = outbound, 1 = inbound).
    function automatic logic [ADDR_W-1:0] ctrl_addr(input int ch);
        return (ch == 0) ? 8'h50 : 8'h80;
    endfunction

    // Base of the four data registers: send0, send1, recv0, recv1 at 8-byte steps.
    function automatic logic [ADDR_W-1:0] data_base(input int ch);
        return (ch == 0) ? 8'h60 : 8'h90;
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
// Module: mbx_fifo
// Circular queue with read/write pointers and an occupancy counter.
// Assumes: a push into a full queue and a pop from an empty queue are ignored.
module mbx_fifo #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 96,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    // Step a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/mbx_channel.sv
// Module: mbx_channel
// One direction of the mailbox: word-0 staging register, queue and sticky
// overflow flag. Assumes at most one of stage/commit/pop per cycle from the bus.
module mbx_channel
    import mbx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_we,
    input  logic              commit_we,
    input  logic              pop_re,
    input  logic              ovf_clr,
    input  logic [DATA_W-1:0] wdata,
    output msg_t              head,
    output logic              full,
    output logic              empty,
    output logic              ovf,
    output logic [CNT_W-1:0]  count,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  wr_ptr
);
    logic [W0_W-1:0] w0_stage;
    msg_t            push_msg;
    logic [$bits(msg_t)-1:0] head_raw;

    assign push_msg = '{w1: wdata[W1_W-1:0], w0: w0_stage};
    assign head     = empty ? '0 : msg_t'(head_raw);

    // Hold the first word until the second word commits the message.
    always_ff @(posedge clk) begin
        if (!rst_n)        w0_stage <= '0;
        else if (stage_we) w0_stage <= wdata[W0_W-1:0];
    end

    // Sticky overflow: set by a commit into a full queue, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf <= 1'b0;
        else if (commit_we && full)  ovf <= 1'b1;
        else if (ovf_clr)            ovf <= 1'b0;
    end

    mbx_fifo #(.DEPTH(DEPTH), .WIDTH($bits(msg_t))) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (commit_we),
        .pop     (pop_re),
        .wr_data (push_msg),
        .rd_data (head_raw),
        .full    (full),
        .empty   (empty),
        .count   (count),
        .rd_ptr  (rd_ptr),
        .wr_ptr  (wr_ptr)
    );

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_we && full) |=> ovf);
    assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_we && !commit_we && !pop_re) |=> $stable(count));
endmodule

// File: rtl/mbx_irq.sv
// Module: mbx_irq
// Sticky level interrupt latches with enable gating. A latch sets when its
// condition is seen and clears on a 1 in its acknowledge bit unless the
// condition is still true in that cycle.
module mbx_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] ack,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] lat_q,
    output logic [N-1:0] en_q,
    output logic [N-1:0] irq
);
    // Enable register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        // Latch: hold unless acknowledged, always re-capture a live condition.
        always_ff @(posedge clk) begin
            if (!rst_n) lat_q[i] <= 1'b0;
            else        lat_q[i] <= (lat_q[i] && !ack[i]) || cond[i];
        end

        assign irq[i] = lat_q[i] && en_q[i];

        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_q[i] && !ack[i]) |=> lat_q[i]);
        assert_reassert_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && cond[i]) |=> lat_q[i]);
    end
endmodule

// File: rtl/ipc_mailbox.sv
// Module: ipc_mailbox (top)
// Two-direction message mailbox behind one register bus. Decodes the register
// map, instantiates one channel per direction and the interrupt latches.
// Assumes FIFO_DEPTH = 16 so that pointers and counts fit the status fields.
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    localparam int PTR_W = $clog2(FIFO_DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_ap_tx_empty,
    output logic              irq_io_rx_ready,
    output logic              irq_io_tx_empty,
    output logic              irq_ap_rx_ready
);
    logic rd_acc, wr_acc;
    logic [NUM_CH-1:0] ch_full, ch_empty, ch_ovf;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];
    logic [NUM_IRQ-1:0] cond, ack, lat, en, irq;

    assign rd_acc = bus_en && !bus_wr;
    assign wr_acc = bus_en && bus_wr;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTRL  = ctrl_addr(c);
        localparam logic [ADDR_W-1:0] A_SEND0 = data_base(c);
        localparam logic [ADDR_W-1:0] A_SEND1 = data_base(c) + 8'd8;
        localparam logic [ADDR_W-1:0] A_RECV0 = data_base(c) + 8'd16;
        localparam logic [ADDR_W-1:0] A_RECV1 = data_base(c) + 8'd24;

        msg_t             head;
        logic [CNT_W-1:0] count;
        logic [PTR_W-1:0] rd_ptr, wr_ptr;

        mbx_channel #(.DEPTH(FIFO_DEPTH)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .stage_we  (wr_acc && bus_addr == A_SEND0),
            .commit_we (wr_acc && bus_addr == A_SEND1),
            .pop_re    (rd_acc && bus_addr == A_RECV1),
            .ovf_clr   (wr_acc && bus_addr == A_CTRL && bus_wdata[CTRL_OVF_BIT]),
            .wdata     (bus_wdata),
            .head      (head),
            .full      (ch_full[c]),
            .empty     (ch_empty[c]),
            .ovf       (ch_ovf[c]),
            .count     (count),
            .rd_ptr    (rd_ptr),
            .wr_ptr    (wr_ptr)
        );

        // Read mux for this channel's registers; zero when not addressed.
        always_comb begin
            ch_rdata[c] = '0;
            if (rd_acc) begin
                if (bus_addr == A_CTRL) begin
                    ch_rdata[c][CTRL_FULL_BIT]  = ch_full[c];
                    ch_rdata[c][CTRL_EMPTY_BIT] = ch_empty[c];
                    ch_rdata[c][CTRL_OVF_BIT]   = ch_ovf[c];
                end else if (bus_addr == A_RECV0) begin
                    ch_rdata[c] = head.w0;
                end else if (bus_addr == A_RECV1) begin
                    ch_rdata[c][W1_W-1:0] = head.w1;
                    ch_rdata[c][ST_OUTCNT_LSB +: ST_OUTCNT_W] = ST_OUTCNT_W'(count);
                    ch_rdata[c][ST_INCNT_LSB  +: ST_INCNT_W]  = ST_INCNT_W'(count);
                    ch_rdata[c][ST_OUTPTR_LSB +: ST_PTR_W]    = ST_PTR_W'(rd_ptr);
                    ch_rdata[c][ST_INPTR_LSB  +: ST_PTR_W]    = ST_PTR_W'(wr_ptr);
                end
            end
        end
    end

    // Interrupt conditions in acknowledge-register bit order.
    assign cond = {!ch_empty[1], ch_empty[1], !ch_empty[0], ch_empty[0]};
    assign ack  = (wr_acc && bus_addr == IRQ_ACK_ADDR) ? bus_wdata[NUM_IRQ-1:0] : '0;

    mbx_irq #(.N(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond     (cond),
        .ack      (ack),
        .en_we    (wr_acc && bus_addr == IRQ_EN_ADDR),
        .en_wdata (bus_wdata[NUM_IRQ-1:0]),
        .lat_q    (lat),
        .en_q     (en),
        .irq      (irq)
    );

    assign irq_ap_tx_empty = irq[0];
    assign irq_io_rx_ready = irq[1];
    assign irq_io_tx_empty = irq[2];
    assign irq_ap_rx_ready = irq[3];

    // Combine channel read data with the interrupt registers.
    always_comb begin
        bus_rdata = '0;
        if (rd_acc && bus_addr == IRQ_EN_ADDR)  bus_rdata[NUM_IRQ-1:0] = en;
        if (rd_acc && bus_addr == IRQ_ACK_ADDR) bus_rdata[NUM_IRQ-1:0] = lat;
        for (int c = 0; c < NUM_CH; c++) bus_rdata = bus_rdata | ch_rdata[c];
    end

    assert_inbound_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_empty[1]) |=> lat[3]);
endmodule

// File: tb/ipc_mailbox_bench.sv
// Bench: vector table for the main data path, then directed tests for reset,
// fill/overflow, empty pops and the interrupt latches.
module ipc_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic irq_ap_tx_empty, irq_io_rx_ready, irq_io_tx_empty, irq_ap_rx_ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ipc_mailbox u_ipc_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ap_tx_empty(irq_ap_tx_empty), .irq_io_rx_ready(irq_io_rx_ready),
        .irq_io_tx_empty(irq_io_tx_empty), .irq_ap_rx_ready(irq_ap_rx_ready)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [63:0] data;   // write data, or expected read data
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h60, 64'h1111_2222_3333_4444, 8'd2},  // R2 stage word0
        '{1'b0, 8'h50, 64'h0000_0000_0002_0000, 8'd2},  // R2 still empty
        '{1'b1, 8'h68, 64'hDEAD_BEEF_CAFE_0001, 8'd2},  // R2 commit
        '{1'b0, 8'h50, 64'h0000_0000_0000_0000, 8'd2},  // R2 not empty
        '{1'b0, 8'h70, 64'h1111_2222_3333_4444, 8'd5},  // R5 head word0
        '{1'b0, 8'h70, 64'h1111_2222_3333_4444, 8'd5},  // R5 no pop on word0
        '{1'b0, 8'h78, 64'h0011_0100_CAFE_0001, 8'd6},  // R6 status + payload
        '{1'b0, 8'h50, 64'h0000_0000_0002_0000, 8'd5},  // R5 popped
        '{1'b1, 8'h90, 64'h5555_6666_7777_8888, 8'd7},  // R7 inbound stage
        '{1'b1, 8'h98, 64'hFFFF_FFFF_0000_0D0D, 8'd2},  // R2 upper half ignored
        '{1'b0, 8'h80, 64'h0000_0000_0000_0000, 8'd7},  // R7 inbound not empty
        '{1'b0, 8'h50, 64'h0000_0000_0002_0000, 8'd7},  // R7 outbound untouched
        '{1'b0, 8'hA0, 64'h5555_6666_7777_8888, 8'd7},  // R7 inbound word0
        '{1'b0, 8'hA8, 64'h0011_0100_0000_0D0D, 8'd6},  // R6 inbound status
        '{1'b0, 8'h80, 64'h0000_0000_0002_0000, 8'd7}   // R7 inbound empty
    };

    // Count a check; print one FAIL line on mismatch.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus write, issued at a falling edge and taken at the next rising edge.
    task automatic do_write(input logic [7:0] a, input logic [63:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    // One bus read; data sampled mid-cycle, side effects at the rising edge.
    task automatic do_read(input logic [7:0] a, output logic [63:0] d);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [63:0] exp);
        logic [63:0] d;
        do_read(a, d);
        check(req, d, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] irq_vec();
        return {60'd0, irq_ap_rx_ready, irq_io_tx_empty, irq_io_rx_ready, irq_ap_tx_empty};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq outputs", irq_vec(), 64'h0);
        rd_check("R1 outbound ctrl", 8'h50, 64'h2_0000);
        rd_check("R1 inbound ctrl", 8'h80, 64'h2_0000);
        rd_check("R1 enables", 8'h48, 64'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data);
            else           rd_check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].data);
        end

        // R3 fill 16 entries, R4 overflow
        for (int i = 0; i < 16; i++) begin
            do_write(8'h60, 64'h0123_0000_0000_0000 + 64'(i));
            do_write(8'h68, 64'h7700_0000 + 64'(i));
        end
        rd_check("R3 full flag", 8'h50, 64'h1_0000);
        do_write(8'h60, 64'hBAD);
        do_write(8'h68, 64'hBAD);
        rd_check("R4 overflow set", 8'h50, 64'h5_0000);
        for (int i = 0; i < 16; i++) begin
            rd_check("R3 order word0", 8'h70, 64'h0123_0000_0000_0000 + 64'(i));
            do_read(8'h78, d);
            if (i == 0) check("R6 full status", d, 64'h0100_1100_7700_0000);
            else        check("R3 order word1", {32'd0, d[31:0]}, 64'h7700_0000 + 64'(i));
        end
        rd_check("R4 overflow sticky", 8'h50, 64'h6_0000);
        do_write(8'h50, 64'h0);
        rd_check("R4 clear needs 1", 8'h50, 64'h6_0000);
        do_write(8'h50, 64'h4_0000);
        rd_check("R4 overflow cleared", 8'h50, 64'h2_0000);

        // R5 pop of an empty queue
        rd_check("R5 empty pop", 8'hA8, 64'h0000_1100_0000_0000);
        rd_check("R5 empty word0", 8'hA0, 64'h0);
        rd_check("R5 still empty", 8'h80, 64'h2_0000);
        rd_check("R5 empty pop no change", 8'hA8, 64'h0000_1100_0000_0000);

        // Interrupts
        idle(1);
        rd_check("R9 all latched", 8'h4C, 64'hF);
        check("R11 gated off", irq_vec(), 64'h0);
        do_write(8'h4C, 64'h0);
        rd_check("R9 ack zero no effect", 8'h4C, 64'hF);
        do_write(8'h4C, 64'hA);
        rd_check("R9 ack clears", 8'h4C, 64'h5);
        do_write(8'h4C, 64'h5);
        rd_check("R10 live condition", 8'h4C, 64'h5);
        do_write(8'h48, 64'h9);
        rd_check("R8 enable readback", 8'h48, 64'h9);
        check("R11 tx empty only", irq_vec(), 64'h1);
        do_write(8'h90, 64'h42);
        do_write(8'h98, 64'h43);
        idle(1);
        check("R11 rx ready", irq_vec(), 64'h9);
        rd_check("R9 latches", 8'h4C, 64'hD);
        do_read(8'hA8, d);
        idle(1);
        check("R9 sticky after drain", irq_vec(), 64'h9);
        do_write(8'h4C, 64'h8);
        rd_check("R9 ack bit3", 8'h4C, 64'h5);
        check("R11 after ack", irq_vec(), 64'h1);
        do_write(8'h48, 64'h6);
        do_write(8'h60, 64'h1);
        do_write(8'h68, 64'h2);
        idle(1);
        check("R11 io side", irq_vec(), 64'h6);
        do_write(8'h4C, 64'h1);
        rd_check("R9 ack stale empty", 8'h4C, 64'h6);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule